// File: doc/BRIEF.md
# 4B/5B Transmit Symbol Encoder with Error-Code Injection

This block sits on the transmit side of a 100 Mb/s Ethernet PHY. Each clock it accepts one 4-bit MII nibble with its transmit-enable and transmit-error qualifiers, and it produces one registered 5-bit code group for the scrambler and line coder that follow. In normal operation it frames each packet. The first two nibbles of a packet are replaced by the start-of-stream pair. Data nibbles are translated through the standard 4B/5B table. When transmit-enable drops, the end-of-stream pair is appended. An error marked during data becomes the Halt symbol, and Idle is sent between packets.

A management test bit adds a diagnostic path. While the bit is set and transmit-error is high, the nibble is mapped through a fixed alternate table instead. That table deliberately yields invalid and control code groups, so downstream decode and error logic can be exercised. While the override is active, the framing sequencer keeps advancing as usual. Only the emitted symbol is replaced.

Top module: `tx4b5b_encoder`

## Requirements
- R1: While reset is high, and on the first cycle after it, the output is Idle 11111 and the framer is in its idle phase.
- R2: With transmit-enable low outside a packet tail and no override, the output is Idle 11111.
- R3: On the first two cycles of transmit-enable high after idle, the output is J 11000 and then K 10001, whatever the nibble.
- R4: Data nibbles after J/K are encoded as follows: 0→11110, 1→01001, 2→10100, 3→10101, 4→01010, 5→01011, 6→01110, 7→01111, 8→10010, 9→10011, A→10110, B→10111, C→11010, D→11011, E→11100, F→11101.
- R5: On the first two cycles after transmit-enable falls in the data phase, the output is T 01101 and then R 00111, and Idle follows.
- R6: In the data phase with the test bit clear, a nibble with transmit-error high is sent as H 00100.
- R7: With the test bit set and transmit-error low, encoding is the same as with the bit clear.
- R8: With the test bit set and transmit-error high, the output is the alternate code of the nibble, in any framing phase: nibbles 0–7 map to 00000–00111 (the nibble with a leading zero), 8→00000, 9→01101, A→01100, B→10001, C→10000, D→11001, E→11000, F→11111. The framing sequence still advances.
- R9: Each code group appears one clock after the inputs that produce it are sampled, and the output holds until then.
- R10: With the test bit clear, transmit-error has no effect outside the data phase (idle, J, K, T, R).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock, one nibble per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| tx_en_i | input | 1 | MII transmit enable |
| tx_er_i | input | 1 | MII transmit error |
| txd_i | input | 4 | MII transmit nibble |
| err_test_i | input | 1 | Management test bit that enables the alternate error-code table |
| code_o | output | 5 | Registered 5-bit code group |

## Verification
Every code group comes from one output register, so it is due exactly one rising edge after the nibble and qualifiers that produce it. The bench changes inputs on the falling edge and reads the code 1 ns after the following rising edge. In one case it also reads just before that edge, to confirm that the previous code group is still held. Framing checks follow the same count: the cycle in which transmit-enable rises yields J, the next yields K, and the first and second low cycles after data yield T and R.

// File: rtl/tx4b5b_pkg.sv
`timescale 1ns/1ps
package tx4b5b_pkg;
  localparam int NIB_W = 4;
  localparam int SYM_W = 5;

  typedef logic [NIB_W-1:0] nib_t;
  typedef logic [SYM_W-1:0] sym_t;

  localparam sym_t SYM_IDLE = 5'b11111;
  localparam sym_t SYM_J    = 5'b11000;
  localparam sym_t SYM_K    = 5'b10001;
  localparam sym_t SYM_T    = 5'b01101;
  localparam sym_t SYM_R    = 5'b00111;
  localparam sym_t SYM_H    = 5'b00100;

  // Symbol selection issued by the framer for the current cycle
  typedef enum logic [2:0] {
    SEL_IDLE, SEL_J, SEL_K, SEL_DATA, SEL_T, SEL_R
  } sel_e;

  // Standard data translation
  function automatic sym_t data_sym(input nib_t n);
    sym_t s;
    case (n)
      4'h0: s = 5'b11110;
      4'h1: s = 5'b01001;
      4'h2: s = 5'b10100;
      4'h3: s = 5'b10101;
      4'h4: s = 5'b01010;
      4'h5: s = 5'b01011;
      4'h6: s = 5'b01110;
      4'h7: s = 5'b01111;
      4'h8: s = 5'b10010;
      4'h9: s = 5'b10011;
      4'hA: s = 5'b10110;
      4'hB: s = 5'b10111;
      4'hC: s = 5'b11010;
      4'hD: s = 5'b11011;
      4'hE: s = 5'b11100;
      default: s = 5'b11101;
    endcase
    return s;
  endfunction

  // Diagnostic translation: lower half passes through, upper half is fixed
  function automatic sym_t test_sym(input nib_t n);
    sym_t s;
    if (!n[NIB_W-1]) begin
      s = {1'b0, n};
    end else begin
      case (n[NIB_W-2:0])
        3'd0: s = 5'b00000;
        3'd1: s = 5'b01101;
        3'd2: s = 5'b01100;
        3'd3: s = 5'b10001;
        3'd4: s = 5'b10000;
        3'd5: s = 5'b11001;
        3'd6: s = 5'b11000;
        default: s = 5'b11111;
      endcase
    end
    return s;
  endfunction
endpackage

// File: rtl/tx4b5b_framer.sv
`timescale 1ns/1ps
module tx4b5b_framer
  import tx4b5b_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tx_en_i,
  output sel_e sel_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_K, ST_DATA, ST_R} st_e;

  st_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    sel_o = SEL_IDLE;
    case (st_q)
      ST_IDLE: begin
        if (tx_en_i) begin
          sel_o = SEL_J;
          st_d  = ST_K;
        end
      end
      ST_K: begin
        sel_o = SEL_K;
        st_d  = ST_DATA;
      end
      ST_DATA: begin
        if (tx_en_i) begin
          sel_o = SEL_DATA;
        end else begin
          sel_o = SEL_T;
          st_d  = ST_R;
        end
      end
      default: begin
        sel_o = SEL_R;
        st_d  = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_IDLE;
    else     st_q <= st_d;
  end
endmodule

// File: rtl/tx4b5b_symbol_mux.sv
`timescale 1ns/1ps
module tx4b5b_symbol_mux
  import tx4b5b_pkg::*;
(
  input  sel_e sel_i,
  input  nib_t txd_i,
  input  logic tx_er_i,
  input  logic err_test_i,
  output sym_t code_o
);
  logic inject;
  assign inject = err_test_i && tx_er_i;

  always_comb begin
    if (inject) begin
      code_o = test_sym(txd_i);
    end else begin
      case (sel_i)
        SEL_J:    code_o = SYM_J;
        SEL_K:    code_o = SYM_K;
        SEL_DATA: code_o = tx_er_i ? SYM_H : data_sym(txd_i);
        SEL_T:    code_o = SYM_T;
        SEL_R:    code_o = SYM_R;
        default:  code_o = SYM_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx4b5b_encoder.sv
`timescale 1ns/1ps
module tx4b5b_encoder
  import tx4b5b_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en_i,
  input  logic             tx_er_i,
  input  logic [NIB_W-1:0] txd_i,
  input  logic             err_test_i,
  output logic [SYM_W-1:0] code_o
);
  sel_e frame_sel;
  sym_t code_d;
  sym_t code_q;

  tx4b5b_framer framer_i (
    .clk     (clk),
    .rst     (rst),
    .tx_en_i (tx_en_i),
    .sel_o   (frame_sel)
  );

  tx4b5b_symbol_mux mux_i (
    .sel_i      (frame_sel),
    .txd_i      (txd_i),
    .tx_er_i    (tx_er_i),
    .err_test_i (err_test_i),
    .code_o     (code_d)
  );

  always_ff @(posedge clk) begin
    if (rst) code_q <= SYM_IDLE;
    else     code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/tx4b5b_checker.sv
`timescale 1ns/1ps
module tx4b5b_checker
  import tx4b5b_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic tx_en_i,
  input logic tx_er_i,
  input nib_t txd_i,
  input logic err_test_i,
  input sym_t code_o,
  input sel_e frame_sel
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> code_o == SYM_IDLE);

  // R2
  idle_out_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_sel == SEL_IDLE && !(err_test_i && tx_er_i)) |=> code_o == SYM_IDLE);

  // R3
  j_then_k_chk: assert property (@(posedge clk) disable iff (rst)
    frame_sel == SEL_J |=> frame_sel == SEL_K);

  // R5
  t_then_r_chk: assert property (@(posedge clk) disable iff (rst)
    frame_sel == SEL_T |=> frame_sel == SEL_R);

  // R6
  halt_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_sel == SEL_DATA && tx_er_i && !err_test_i) |=> code_o == SYM_H);

  // R7
  test_no_er_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_sel == SEL_DATA && err_test_i && !tx_er_i && tx_en_i)
      |=> code_o == data_sym($past(txd_i)));

  // R8
  inject_chk: assert property (@(posedge clk) disable iff (rst)
    (err_test_i && tx_er_i) |=> code_o == test_sym($past(txd_i)));
endmodule

bind tx4b5b_encoder tx4b5b_checker chk_i (
  .clk        (clk),
  .rst        (rst),
  .tx_en_i    (tx_en_i),
  .tx_er_i    (tx_er_i),
  .txd_i      (txd_i),
  .err_test_i (err_test_i),
  .code_o     (code_o),
  .frame_sel  (frame_sel)
);

// File: tb/tx4b5b_encoder_tb_top.sv
`timescale 1ns/1ps
module tx4b5b_encoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0;
  logic       tx_er = 1'b0;
  logic [3:0] txd = 4'h0;
  logic       tst = 1'b0;
  logic [4:0] code;

  int n_chk = 0;
  int n_fail = 0;

  localparam logic [4:0] E_IDLE = 5'b11111;
  localparam logic [4:0] E_J = 5'b11000;
  localparam logic [4:0] E_K = 5'b10001;
  localparam logic [4:0] E_T = 5'b01101;
  localparam logic [4:0] E_R = 5'b00111;
  localparam logic [4:0] E_H = 5'b00100;

  always #5 clk = ~clk;

  tx4b5b_encoder dut_i (
    .clk        (clk),
    .rst        (rst),
    .tx_en_i    (tx_en),
    .tx_er_i    (tx_er),
    .txd_i      (txd),
    .err_test_i (tst),
    .code_o     (code)
  );

  function automatic logic [4:0] ref_data(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                           5'b01010, 5'b01011, 5'b01110, 5'b01111,
                           5'b10010, 5'b10011, 5'b10110, 5'b10111,
                           5'b11010, 5'b11011, 5'b11100, 5'b11101};
    return t[n];
  endfunction

  function automatic logic [4:0] ref_test(input logic [3:0] n);
    logic [4:0] t [16] = '{5'b00000, 5'b00001, 5'b00010, 5'b00011,
                           5'b00100, 5'b00101, 5'b00110, 5'b00111,
                           5'b00000, 5'b01101, 5'b01100, 5'b10001,
                           5'b10000, 5'b11001, 5'b11000, 5'b11111};
    return t[n];
  endfunction

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // Drive at the falling edge, read 1 ns after the next rising edge
  task automatic step(input logic en, input logic er, input logic ts,
                      input logic [3:0] d, output logic [4:0] c);
    @(negedge clk);
    tx_en = en; tx_er = er; tst = ts; txd = d;
    @(posedge clk);
    #1 c = code;
  endtask

  task automatic t_reset();
    logic [4:0] c;
    rst = 1'b1;
    step(1'b1, 1'b1, 1'b1, 4'h5, c);
    check("R1 in reset", c, E_IDLE);
    step(1'b0, 1'b0, 1'b0, 4'h0, c);
    check("R1 in reset", c, E_IDLE);
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    check("R1 after reset", code, E_IDLE);
  endtask

  task automatic t_idle();
    logic [4:0] c;
    step(1'b0, 1'b0, 1'b0, 4'h3, c);
    check("R2 idle", c, E_IDLE);
    step(1'b0, 1'b0, 1'b0, 4'hC, c);
    check("R2 idle", c, E_IDLE);
    step(1'b0, 1'b1, 1'b0, 4'h4, c);
    check("R10 tx_er while idle", c, E_IDLE);
    step(1'b0, 1'b0, 1'b1, 4'h7, c);
    check("R7 test bit idle", c, E_IDLE);
  endtask

  task automatic t_frame_all();
    logic [4:0] c;
    step(1'b1, 1'b0, 1'b0, 4'hA, c);
    check("R3 J", c, E_J);
    step(1'b1, 1'b0, 1'b0, 4'h3, c);
    check("R3 K", c, E_K);
    for (int i = 0; i < 16; i++) begin
      step(1'b1, 1'b0, 1'b0, 4'(i), c);
      check("R4 data", c, ref_data(4'(i)));
    end
    step(1'b0, 1'b0, 1'b0, 4'h0, c);
    check("R5 T", c, E_T);
    step(1'b0, 1'b0, 1'b0, 4'h0, c);
    check("R5 R", c, E_R);
    step(1'b0, 1'b0, 1'b0, 4'h0, c);
    check("R5 idle after R", c, E_IDLE);
  endtask

  task automatic t_halt();
    logic [4:0] c;
    step(1'b1, 1'b1, 1'b0, 4'h9, c);
    check("R10 tx_er on J", c, E_J);
    step(1'b1, 1'b1, 1'b0, 4'h9, c);
    check("R10 tx_er on K", c, E_K);
    step(1'b1, 1'b1, 1'b0, 4'h5, c);
    check("R6 halt", c, E_H);
    step(1'b1, 1'b0, 1'b0, 4'h5, c);
    check("R6 data after halt", c, ref_data(4'h5));
    step(1'b0, 1'b1, 1'b0, 4'h0, c);
    check("R10 tx_er on T", c, E_T);
    step(1'b0, 1'b1, 1'b0, 4'h0, c);
    check("R10 tx_er on R", c, E_R);
    step(1'b0, 1'b0, 1'b0, 4'h0, c);
    check("R2 idle", c, E_IDLE);
  endtask

  task automatic t_test_no_er();
    logic [4:0] c;
    step(1'b1, 1'b0, 1'b1, 4'h0, c);
    check("R7 J", c, E_J);
    step(1'b1, 1'b0, 1'b1, 4'h0, c);
    check("R7 K", c, E_K);
    for (int i = 0; i < 16; i += 3) begin
      step(1'b1, 1'b0, 1'b1, 4'(i), c);
      check("R7 data", c, ref_data(4'(i)));
    end
    step(1'b0, 1'b0, 1'b1, 4'h0, c);
    check("R7 T", c, E_T);
    step(1'b0, 1'b0, 1'b1, 4'h0, c);
    check("R7 R", c, E_R);
    step(1'b0, 1'b0, 1'b0, 4'h0, c);
    check("R2 idle", c, E_IDLE);
  endtask

  task automatic t_inject();
    logic [4:0] c;
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b1, 1'b1, 4'(i), c);
      check("R8 table idle", c, ref_test(4'(i)));
    end
    step(1'b0, 1'b0, 1'b1, 4'h0, c);
    check("R2 idle after inject", c, E_IDLE);
    // override on the J cycle; sequencer still advances to K
    step(1'b1, 1'b1, 1'b1, 4'h0, c);
    check("R8 override J", c, ref_test(4'h0));
    step(1'b1, 1'b0, 1'b1, 4'h0, c);
    check("R8 K after override", c, E_K);
    step(1'b1, 1'b1, 1'b1, 4'h7, c);
    check("R8 data R", c, ref_test(4'h7));
    step(1'b1, 1'b1, 1'b1, 4'hE, c);
    check("R8 data J", c, ref_test(4'hE));
    step(1'b1, 1'b0, 1'b1, 4'h2, c);
    check("R7 data", c, ref_data(4'h2));
    step(1'b0, 1'b0, 1'b1, 4'h0, c);
    check("R5 T", c, E_T);
    step(1'b0, 1'b0, 1'b1, 4'h0, c);
    check("R5 R", c, E_R);
    step(1'b0, 1'b0, 1'b0, 4'h0, c);
    check("R2 idle", c, E_IDLE);
  endtask

  task automatic t_latency();
    logic [4:0] c;
    @(negedge clk);
    tx_en = 1'b1; tx_er = 1'b0; tst = 1'b0; txd = 4'h1;
    #1 check("R9 held before edge", code, E_IDLE);
    @(posedge clk);
    #1 check("R9 J after one edge", code, E_J);
    step(1'b1, 1'b0, 1'b0, 4'h1, c);
    step(1'b1, 1'b0, 1'b0, 4'hB, c);
    @(negedge clk);
    tx_en = 1'b0;
    #1 check("R9 data held", code, ref_data(4'hB));
    @(posedge clk);
    #1 check("R9 T after edge", code, E_T);
    step(1'b0, 1'b0, 1'b0, 4'h0, c);
    step(1'b0, 1'b0, 1'b0, 4'h0, c);
    check("R2 idle", c, E_IDLE);
  endtask

  initial begin
    t_reset();
    t_idle();
    t_frame_all();
    t_halt();
    t_test_no_er();
    t_inject();
    t_latency();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule